// File: doc/BRIEF.md
# Binary Field Square and Square-Root Unit

This unit takes one element of GF(2^163), held in polynomial basis over the fixed pentanomial f(z) = z^163 + z^7 + z^6 + z^3 + 1, and returns either its square or its square root. A single mode bit chosen at launch selects the operation. The operand is first cut into two nibble streams. The low stream takes bits 0..3 of every byte. The high stream takes bits 4..7 of every byte, moved down by four places. Both operations are then built from small 4-bit lookups on these streams.

For squaring, each nibble expands to a byte with zeros between its bits. The expanded low and high bytes are interleaved, so coefficient a_i moves to position 2i. For the square root, each nibble gives up its even-indexed pair and its odd-indexed pair. This forms a half-length even polynomial and a half-length odd polynomial. The odd polynomial is multiplied by a fixed constant equal to the square root of z, and the even polynomial is added to the product. The constant is computed at elaboration.

Both unreduced results go through one shared reducer. The reducer folds the bits above degree 162 back down by one word per clock. The result appears on a registered output bus, and a one-cycle completion pulse marks it.

Top module: `gf_sqr_root_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `res_out` are all zero.
- R2: With `mode` = 0 at launch, `res_out` equals op_in^2 mod f(z), where f(z) = z^163 + z^7 + z^6 + z^3 + 1.
- R3: With `mode` = 1 at launch, `res_out` is the unique r with r^2 mod f(z) = op_in. Squaring that r in mode 0 gives back the operand, and taking the root of a square gives back the original element.
- R4: `done` is high for exactly one cycle. It rises at the clock edge that comes NW edges after the launching edge, where NW = ceil(162 / WORD_W) (6 for the default WORD_W = 32).
- R5: A launch happens at a rising edge where `start` is high and `busy` is low. From that edge `busy` is high, and it falls at the edge where `done` rises. A `start` seen while `busy` is high is ignored: it produces no further result and no further `done` pulse.
- R6: `res_out` changes only at the edge where `done` rises, and otherwise holds its value.
- R7: The operand and mode are sampled only at the launching edge. Changing `op_in` or `mode` while busy has no effect on the result.
- R8: The elements 0 and 1 map to themselves in both modes. The all-ones element and z^162 give their field-correct square and root.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only when idle |
| mode | input | 1 | 0 = square, 1 = square root |
| op_in | input | 163 | Field element operand, bit i is the coefficient of z^i |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `res_out` holds a new result |
| res_out | output | 163 | Registered, fully reduced result |

## Verification
A wrong entry in a nibble lookup, or a wrong bit of the square-root constant, corrupts `res_out` for a large fraction of operands. It becomes visible on the very `done` pulse of the affected operation. Comparing the root against repeated squaring catches such an error, and so do the square/root round trips. A miscounted fold step shows up either as `done` arriving on the wrong edge, or as unreduced high bits folded into the wrong place, which gives a wrong result on that same pulse. A launch that slipped through while busy would show as a second `done` pulse or a changed `res_out` within a few cycles of the first result.

// File: rtl/gf_sqr_pkg.sv
package gf_sqr_pkg;

  // Field degree and low-order terms of the reduction pentanomial
  localparam int FIELD_M = 163;
  localparam int TAP_W   = 8;
  localparam logic [TAP_W-1:0] POLY_TAPS = 8'b1100_1001; // z^7 + z^6 + z^3 + 1

  typedef logic [FIELD_M-1:0] gf_elem_t;

  localparam logic OP_SQUARE = 1'b0;
  localparam logic OP_ROOT   = 1'b1;

  // nibble (u3,u2,u1,u0) -> byte (0,u3,0,u2,0,u1,0,u0)
  function automatic logic [7:0] nib_spread(input logic [3:0] u);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) r[2*i] = u[i];
    return r;
  endfunction

  // even-indexed coefficients of a nibble, compressed
  function automatic logic [1:0] nib_even(input logic [3:0] u);
    return {u[2], u[0]};
  endfunction

  // odd-indexed coefficients of a nibble, compressed
  function automatic logic [1:0] nib_odd(input logic [3:0] u);
    return {u[3], u[1]};
  endfunction

  // sqrt(z) = z^(2^(m-1)) mod f, by m-1 repeated squarings
  function automatic gf_elem_t sqrt_z_const();
    gf_elem_t x;
    logic [2*FIELD_M-2:0] w;
    x = '0;
    x[1] = 1'b1;
    for (int i = 0; i < FIELD_M - 1; i++) begin
      w = '0;
      for (int j = 0; j < FIELD_M; j++) w[2*j] = x[j];
      for (int p = 2*FIELD_M - 2; p >= FIELD_M; p--) begin
        if (w[p]) begin
          w[p] = 1'b0;
          for (int t = 0; t < TAP_W; t++)
            if (POLY_TAPS[t]) w[p-FIELD_M+t] = ~w[p-FIELD_M+t];
        end
      end
      x = w[FIELD_M-1:0];
    end
    return x;
  endfunction

  localparam gf_elem_t SQRT_Z = sqrt_z_const();

endpackage

// File: rtl/gf_nib_split.sv
module gf_nib_split import gf_sqr_pkg::*; #(
  parameter int M = FIELD_M,
  localparam int NB = (M + 7) / 8,
  localparam int HW = 4 * NB
) (
  input  logic [M-1:0]  a,
  output logic [HW-1:0] lo_nib,
  output logic [HW-1:0] hi_nib
);
  logic [8*NB-1:0] padded;
  assign padded = {{(8*NB-M){1'b0}}, a};

  // low stream: mask 0x0F per byte; high stream: mask 0xF0 per byte, then down by 4
  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign lo_nib[4*j +: 4] = padded[8*j +: 4];
    assign hi_nib[4*j +: 4] = padded[8*j+4 +: 4];
  end
endmodule

// File: rtl/gf_sq_expand.sv
module gf_sq_expand import gf_sqr_pkg::*; #(
  parameter int M = FIELD_M,
  parameter int OUT_W = 2*FIELD_M,
  localparam int NB = (M + 7) / 8,
  localparam int HW = 4 * NB,
  localparam int SQ_W = 16 * NB
) (
  input  logic [HW-1:0]    lo_nib,
  input  logic [HW-1:0]    hi_nib,
  output logic [OUT_W-1:0] sq_raw
);
  logic [SQ_W-1:0] inter;

  // low^2 + high^2 * z^8: looked-up bytes interleaved low/high
  for (genvar j = 0; j < NB; j++) begin : g_ilv
    assign inter[16*j +: 8]   = nib_spread(lo_nib[4*j +: 4]);
    assign inter[16*j+8 +: 8] = nib_spread(hi_nib[4*j +: 4]);
  end

  assign sq_raw = {{(OUT_W-SQ_W){1'b0}}, inter};
endmodule

// File: rtl/gf_root_expand.sv
module gf_root_expand import gf_sqr_pkg::*; #(
  parameter int M = FIELD_M,
  parameter int OUT_W = 2*FIELD_M,
  localparam int NB = (M + 7) / 8,
  localparam int HW = 4 * NB
) (
  input  logic [HW-1:0]    lo_nib,
  input  logic [HW-1:0]    hi_nib,
  output logic [OUT_W-1:0] root_raw
);
  logic [HW-1:0]    even_h;
  logic [HW-1:0]    odd_h;
  logic [OUT_W-1:0] prod;

  // low_even + high_even*z^2, low_odd + high_odd*z^2 per byte
  for (genvar j = 0; j < NB; j++) begin : g_sep
    assign even_h[4*j +: 4] = {nib_even(hi_nib[4*j +: 4]), nib_even(lo_nib[4*j +: 4])};
    assign odd_h[4*j +: 4]  = {nib_odd(hi_nib[4*j +: 4]),  nib_odd(lo_nib[4*j +: 4])};
  end

  // carry-less product of the odd half with the constant sqrt(z)
  always_comb begin
    prod = '0;
    for (int k = 0; k < HW; k++)
      if (odd_h[k]) prod = prod ^ (OUT_W'(SQRT_Z) << k);
  end

  assign root_raw = prod ^ OUT_W'(even_h);
endmodule

// File: rtl/gf_fold_reducer.sv
module gf_fold_reducer import gf_sqr_pkg::*; #(
  parameter int M = FIELD_M,
  parameter int W = 32,
  localparam int NW = (M - 1 + W - 1) / W,
  localparam int RW = M + NW * W,
  localparam int SW = W + TAP_W,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [RW-1:0] load_val,
  output logic          busy,
  output logic          done,
  output logic [M-1:0]  res
);
  localparam logic [RW-1:0] CHUNK_MASK = RW'({W{1'b1}});

  logic [RW-1:0] acc, acc_nx, top_rest;
  logic [CW-1:0] cnt;
  logic [W-1:0]  chunk;
  logic [SW-1:0] spread;
  logic          busy_q, done_q;
  logic [M-1:0]  res_q;
  int            fold_idx, fold_base;

  // fold the word at [base, base+W) down by M, times (z^7+z^6+z^3+1)
  always_comb begin
    fold_idx  = NW - 1 - int'(cnt);
    fold_base = M + fold_idx * W;
    chunk     = W'(acc >> fold_base);
    spread    = '0;
    for (int t = 0; t < TAP_W; t++)
      if (POLY_TAPS[t]) spread = spread ^ (SW'(chunk) << t);
    acc_nx   = (acc & ~(CHUNK_MASK << fold_base)) ^ (RW'(spread) << (fold_idx * W));
    top_rest = acc >> (fold_base + W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && load) begin
        acc    <= load_val;
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc <= acc_nx;
        if (cnt == CW'(NW - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= acc_nx[M-1:0];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign res  = res_q;

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt < CW'(NW)));

  // R2
  fold_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (top_rest == '0));
endmodule

// File: rtl/gf_sqr_root_unit.sv
module gf_sqr_root_unit import gf_sqr_pkg::*; #(
  parameter int WORD_W = 32,
  localparam int M  = FIELD_M,
  localparam int NW = (M - 1 + WORD_W - 1) / WORD_W,
  localparam int RW = M + NW * WORD_W,
  localparam int HW = 4 * ((M + 7) / 8)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         mode,
  input  logic [M-1:0] op_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] res_out
);
  logic [HW-1:0] lo_nib, hi_nib;
  logic [RW-1:0] sq_raw, root_raw, unreduced;
  logic          launch;

  gf_nib_split #(.M(M)) u_split (
    .a(op_in), .lo_nib(lo_nib), .hi_nib(hi_nib)
  );

  gf_sq_expand #(.M(M), .OUT_W(RW)) u_sq (
    .lo_nib(lo_nib), .hi_nib(hi_nib), .sq_raw(sq_raw)
  );

  gf_root_expand #(.M(M), .OUT_W(RW)) u_root (
    .lo_nib(lo_nib), .hi_nib(hi_nib), .root_raw(root_raw)
  );

  assign unreduced = (mode == OP_ROOT) ? root_raw : sq_raw;
  assign launch    = start && !busy;

  gf_fold_reducer #(.M(M), .W(WORD_W)) u_red (
    .clk(clk), .rst(rst), .load(launch), .load_val(unreduced),
    .busy(busy), .done(done), .res(res_out)
  );

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R5
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res_out));
endmodule

// File: tb/tb_gf_sqr_root_unit.sv
module tb_gf_sqr_root_unit;
  localparam int M   = 163;
  localparam int WW  = 32;
  localparam int LAT = (M - 1 + WW - 1) / WW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [M-1:0] op_in = '0;
  logic         busy, done;
  logic [M-1:0] res_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gf_sqr_root_unit #(.WORD_W(WW)) dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .op_in(op_in), .busy(busy), .done(done), .res_out(res_out)
  );

  function automatic logic [M-1:0] ref_sq(input logic [M-1:0] a);
    logic [2*M-2:0] w;
    w = '0;
    for (int j = 0; j < M; j++) w[2*j] = a[j];
    for (int p = 2*M-2; p >= M; p--) begin
      if (w[p]) begin
        w[p] = 1'b0;
        w[p-M]   = ~w[p-M];
        w[p-M+3] = ~w[p-M+3];
        w[p-M+6] = ~w[p-M+6];
        w[p-M+7] = ~w[p-M+7];
      end
    end
    return w[M-1:0];
  endfunction

  function automatic logic [M-1:0] ref_root(input logic [M-1:0] a);
    logic [M-1:0] x;
    x = a;
    for (int i = 0; i < M - 1; i++) x = ref_sq(x);
    return x;
  endfunction

  function automatic logic [M-1:0] rand_elem();
    logic [191:0] x;
    x = '0;
    for (int k = 0; k < 6; k++) x = {x[159:0], $urandom()};
    return x[M-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                       input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // launch one operation and check busy, latency, result and pulse width
  task automatic run_op(input logic md, input logic [M-1:0] a, input logic [M-1:0] exp,
                        input string req, input bit disturb);
    int n;
    @(negedge clk);
    op_in = a; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R5 busy after launch", M'(busy), M'(1));
    n = 0;
    if (disturb) begin
      op_in = ~a; mode = ~md; start = 1'b1;   // R7 / R5: ignored while busy
    end
    while (done !== 1'b1 && n < 100) begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    check(n == LAT, "R4 latency", M'(n), M'(LAT));
    check(res_out === exp, req, res_out, exp);
    check(busy === 1'b0, "R5 busy low at done", M'(busy), M'(0));
    @(negedge clk);
    check(done === 1'b0, "R4 one-cycle done", M'(done), M'(0));
    if (disturb) begin
      for (int i = 0; i < LAT + 3; i++) begin
        @(negedge clk);
        check(done === 1'b0 && res_out === exp, "R5 R6 no extra result", res_out, exp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [M-1:0] a, r, top;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && res_out === '0, "R1 in reset", res_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && res_out === '0, "R1 after reset", res_out, '0);

    // R8 corner elements
    run_op(1'b0, '0, '0, "R8 zero square", 1'b0);
    run_op(1'b1, '0, '0, "R8 zero root", 1'b0);
    run_op(1'b0, M'(1), M'(1), "R8 one square", 1'b0);
    run_op(1'b1, M'(1), M'(1), "R8 one root", 1'b0);
    a = '1;
    run_op(1'b0, a, ref_sq(a), "R8 all-ones square", 1'b0);
    run_op(1'b1, a, ref_root(a), "R8 all-ones root", 1'b0);
    top = '0; top[M-1] = 1'b1;
    run_op(1'b0, top, ref_sq(top), "R8 z^162 square", 1'b0);
    run_op(1'b1, top, ref_root(top), "R8 z^162 root", 1'b0);

    // R7 / R5: operand and mode changed and start re-pulsed while busy
    a = rand_elem();
    run_op(1'b0, a, ref_sq(a), "R7 square held", 1'b1);
    a = rand_elem();
    run_op(1'b1, a, ref_root(a), "R7 root held", 1'b1);

    // R2 / R3 random operands and round trips
    for (int i = 0; i < 12; i++) begin
      a = rand_elem();
      run_op(1'b0, a, ref_sq(a), "R2 square", 1'b0);
      r = ref_root(a);
      run_op(1'b1, a, r, "R3 root", 1'b0);
      run_op(1'b0, r, a, "R3 root then square", 1'b0);
      run_op(1'b1, ref_sq(a), a, "R3 square then root", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule